// File: doc/BRIEF.md
# UART Status and Interrupt Flag Unit

This block keeps the status flags of a UART-style serial port and merges them into one interrupt request line. The receiver and transmitter datapaths send it single-cycle event pulses: a frame has arrived, a parity or framing error occurred, there was noise on a start bit, the line went idle, a character matched, or the transmitter moved data into its shift register or finished a frame. The block also watches the clear-to-send pin and the bus-side strobes: the data-register read, the data-register write, the flush request and the break request. Software clears most flags through a write-one-to-clear port.

The flags depend on each other. Overrun is decided against the receive-ready flag. The idle flag is re-armed only by a received frame and is ignored while the receiver is muted. Transmit-complete is forced on while the transmitter is disabled and not busy. The block drives the status word from its flag registers. It drives the interrupt output from a register that combines every flag with its enable.

Top module: `uart_flag_unit`

## Requirements
- R1: After a synchronous reset, every bit of `status` is 0 except bit 7 (transmit empty), which is 1. `irq` is 0.
- R2: Each of these status bits reads 1 in the cycle after its event pulse: bit 0 (parity), bit 1 (framing), bit 2 (noise) and bit 11 (character match). A `clr_wr` strobe clears a flag when the matching bit of `clr_data` is 1. A 0 in that position leaves the flag unchanged.
- R3: When a hardware set and a software clear reach the same flag in the same cycle, the flag ends up 1.
- R4: When `ev_frame_rx` arrives while bit 5 (receive ready) is already 1, bit 3 (overrun) sets and bit 5 stays 1.
- R5: While `cfg_ovr_dis` is 1, bit 3 is held at 0. This holds even when an overrun condition occurs.
- R6: Bit 5 sets on `ev_frame_rx`. It clears on `rdr_read` or on `rx_flush`.
- R7: Bit 4 (idle) sets on `ev_idle` only if the idle detector is armed and `mute` is 0. The detector is armed out of reset. A successful idle set disarms it, and only `ev_frame_rx` re-arms it.
- R8: Bit 6 (transmit complete) sets on `ev_tx_done` only while bit 7 is 1. It clears through `clr_data` bit 6 or on `tdr_write`. While `cfg_tx_en` is 0 and `tx_busy` is 0, it is forced to 1 and ignores clears.
- R9: Bit 7 sets on `ev_tx_load` and clears on `tdr_write`. If both occur in the same cycle, the write wins and the bit ends up 0.
- R10: Bit 9 equals the inverse of `cts_n_in` after `SYNC_STAGES` clock edges. Bit 8 (CTS change) sets one edge later on each toggle, but only while `cfg_cts_flow_en` is 1.
- R11: Bit 10 (busy) sets on `ev_rx_start` and clears on `ev_rx_end`. Bit 12 (break pending) sets on `break_req` and clears on `ev_break_done`.
- R12: `irq` goes to 1 one cycle after an enabled flag is 1. The enable bits of `ie` map as follows:
  - `ie` bit 0: parity.
  - `ie` bit 1: framing, noise or overrun.
  - `ie` bit 2: idle.
  - `ie` bit 3: receive ready or overrun.
  - `ie` bit 4: transmit complete.
  - `ie` bit 5: transmit empty.
  - `ie` bit 6: CTS change.
  - `ie` bit 7: character match.
  
  Noise raises no interrupt through `ie` bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_frame_err | input | 1 | Framing error / break detected pulse |
| ev_noise | input | 1 | Start-bit noise pulse |
| ev_frame_rx | input | 1 | Received frame moves to data register |
| ev_idle | input | 1 | Idle line detected pulse |
| ev_char_match | input | 1 | Matching character received |
| ev_tx_load | input | 1 | Transmit data register moved to shifter |
| ev_tx_done | input | 1 | Data frame finished on the line |
| ev_break_done | input | 1 | Stop bit of break frame reached |
| ev_rx_start | input | 1 | Valid start bit seen |
| ev_rx_end | input | 1 | Reception ended |
| tx_busy | input | 1 | Transmitter is still sending |
| cts_n_in | input | 1 | Asynchronous clear-to-send pin, active low |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_cts_flow_en | input | 1 | CTS flow control enable |
| cfg_ovr_dis | input | 1 | Overrun detection disable |
| mute | input | 1 | Receiver is in mute |
| ie | input | 8 | Interrupt enables |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 13 | Write-one-to-clear data |
| rdr_read | input | 1 | Receive data register read |
| rx_flush | input | 1 | Receive flush request |
| tdr_write | input | 1 | Transmit data register write |
| break_req | input | 1 | Software break request |
| status | output | 13 | Flag word |
| rx_ready | output | 1 | Receive data register full |
| tx_empty | output | 1 | Transmit data register empty |
| irq | output | 1 | Registered interrupt request |

## Verification
Every event, strobe and configuration input reaches its `status` bit at the first rising edge. The bench drives inputs on falling edges and reads the flags at the next falling edge. `irq` adds one more register, so it is read one falling edge after the flag. The CTS level needs `SYNC_STAGES` edges, and the change flag needs one more; the bench waits exactly those counts before each check. Checks that an input has no effect are read at the first falling edge where the change would have appeared.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int STAT_W = 13;
  localparam int IE_W   = 8;
  // status bit positions (software decodes these)
  localparam int B_PAR = 0;
  localparam int B_FRM = 1;
  localparam int B_NOI = 2;
  localparam int B_OVR = 3;
  localparam int B_IDL = 4;
  localparam int B_RXR = 5;
  localparam int B_TCF = 6;
  localparam int B_TXE = 7;
  localparam int B_CCH = 8;
  localparam int B_CTL = 9;
  localparam int B_BSY = 10;
  localparam int B_CMT = 11;
  localparam int B_BRK = 12;
  // interrupt enable positions
  localparam int E_PAR = 0;
  localparam int E_ERR = 1;
  localparam int E_IDL = 2;
  localparam int E_RXR = 3;
  localparam int E_TCF = 4;
  localparam int E_TXE = 5;
  localparam int E_CCH = 6;
  localparam int E_CMT = 7;
  // flags that the clear register may touch
  localparam logic [STAT_W-1:0] W1C_MASK =
    STAT_W'((1 << B_PAR) | (1 << B_FRM) | (1 << B_NOI) | (1 << B_OVR) |
            (1 << B_IDL) | (1 << B_TCF) | (1 << B_CCH) | (1 << B_CMT));
endpackage

// File: rtl/uart_flag_cell.sv
module uart_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic force0_i,
  input  logic force1_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)           q_o <= RST_VAL;
    else if (force1_i) q_o <= 1'b1;
    else if (force0_i) q_o <= 1'b0;
    else if (set_i)    q_o <= 1'b1;
    else if (clr_i)    q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic toggle_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b1;
        else     chain[s] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b1;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b1;
    else     last <= chain[STAGES-1];
  end

  assign level_o  = chain[STAGES-1];
  assign toggle_o = chain[STAGES-1] ^ last;
endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] flags_i,
  input  logic [IE_W-1:0]   ie_i,
  output logic              irq_o
);
  logic req;

  always_comb begin
    req = (flags_i[B_PAR] & ie_i[E_PAR])
        | ((flags_i[B_FRM] | flags_i[B_NOI] | flags_i[B_OVR]) & ie_i[E_ERR])
        | (flags_i[B_IDL] & ie_i[E_IDL])
        | ((flags_i[B_RXR] | flags_i[B_OVR]) & ie_i[E_RXR])
        | (flags_i[B_TCF] & ie_i[E_TCF])
        | (flags_i[B_TXE] & ie_i[E_TXE])
        | (flags_i[B_CCH] & ie_i[E_CCH])
        | (flags_i[B_CMT] & ie_i[E_CMT]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= req;
  end
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
  import uart_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_parity_err,
  input  logic              ev_frame_err,
  input  logic              ev_noise,
  input  logic              ev_frame_rx,
  input  logic              ev_idle,
  input  logic              ev_char_match,
  input  logic              ev_tx_load,
  input  logic              ev_tx_done,
  input  logic              ev_break_done,
  input  logic              ev_rx_start,
  input  logic              ev_rx_end,
  input  logic              tx_busy,
  input  logic              cts_n_in,
  input  logic              cfg_tx_en,
  input  logic              cfg_cts_flow_en,
  input  logic              cfg_ovr_dis,
  input  logic              mute,
  input  logic [IE_W-1:0]   ie,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_data,
  input  logic              rdr_read,
  input  logic              rx_flush,
  input  logic              tdr_write,
  input  logic              break_req,
  output logic [STAT_W-1:0] status,
  output logic              rx_ready,
  output logic              tx_empty,
  output logic              irq
);
  logic [STAT_W-1:0] flags;
  logic [STAT_W-1:0] set_v, clr_v, f0_v, f1_v, sw_clr;
  logic              cts_sync_lvl, cts_toggle;
  logic              idle_armed, idle_hit;

  uart_cts_sync #(.STAGES(SYNC_STAGES)) i_cts (
    .clk(clk), .rst(rst), .pin_i(cts_n_in),
    .level_o(cts_sync_lvl), .toggle_o(cts_toggle)
  );

  assign idle_hit = ev_idle & idle_armed & ~mute;

  always_ff @(posedge clk) begin
    if (rst)              idle_armed <= 1'b1;
    else if (ev_frame_rx) idle_armed <= 1'b1;
    else if (idle_hit)    idle_armed <= 1'b0;
  end

  always_comb begin
    sw_clr = clr_wr ? (clr_data & W1C_MASK) : '0;
    set_v  = '0;
    clr_v  = sw_clr;
    f0_v   = '0;
    f1_v   = '0;

    set_v[B_PAR] = ev_parity_err;
    set_v[B_FRM] = ev_frame_err;
    set_v[B_NOI] = ev_noise;
    set_v[B_CMT] = ev_char_match;

    set_v[B_OVR] = ev_frame_rx & flags[B_RXR];
    f0_v[B_OVR]  = cfg_ovr_dis;

    set_v[B_RXR] = ev_frame_rx;
    clr_v[B_RXR] = rdr_read | rx_flush;

    set_v[B_IDL] = idle_hit;

    set_v[B_TCF] = ev_tx_done & flags[B_TXE];
    clr_v[B_TCF] = sw_clr[B_TCF] | tdr_write;
    f1_v[B_TCF]  = ~cfg_tx_en & ~tx_busy;

    // a data-register write in the load cycle refills the register
    set_v[B_TXE] = ev_tx_load & ~tdr_write;
    clr_v[B_TXE] = tdr_write;

    set_v[B_CCH] = cts_toggle & cfg_cts_flow_en;

    set_v[B_BSY] = ev_rx_start;
    clr_v[B_BSY] = ev_rx_end;

    set_v[B_BRK] = break_req;
    clr_v[B_BRK] = ev_break_done;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (i == B_CTL) begin : g_level
      assign flags[i] = ~cts_sync_lvl;
    end else begin : g_cell
      uart_flag_cell #(.RST_VAL(i == B_TXE)) i_cell (
        .clk(clk), .rst(rst),
        .set_i(set_v[i]), .clr_i(clr_v[i]),
        .force0_i(f0_v[i]), .force1_i(f1_v[i]),
        .q_o(flags[i])
      );
    end
  end

  uart_flag_irq i_irq (
    .clk(clk), .rst(rst), .flags_i(flags), .ie_i(ie), .irq_o(irq)
  );

  assign status   = flags;
  assign rx_ready = flags[B_RXR];
  assign tx_empty = flags[B_TXE];
endmodule

// File: rtl/uart_flag_unit_chk.sv
module uart_flag_unit_chk
  import uart_flag_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ev_parity_err,
  input logic              ev_frame_rx,
  input logic              tx_busy,
  input logic              cfg_tx_en,
  input logic              cfg_ovr_dis,
  input logic              mute,
  input logic [IE_W-1:0]   ie,
  input logic              clr_wr,
  input logic [STAT_W-1:0] clr_data,
  input logic              tdr_write,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  // R2 / R3: a parity event always leaves the flag set, clear or not
  p_parity_set_r3: assert property (@(posedge clk) disable iff (rst)
    ev_parity_err |=> status[B_PAR]);

  // R2: writing 0 in the parity position does not clear it
  p_zero_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (status[B_PAR] && !(clr_wr && clr_data[B_PAR])) |=> status[B_PAR]);

  // R4: overrun on a second frame
  p_overrun_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_frame_rx && status[B_RXR] && !cfg_ovr_dis) |=> (status[B_OVR] && status[B_RXR]));

  // R5: overrun held low while disabled
  p_ovr_off_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_ovr_dis |=> !status[B_OVR]);

  // R7: muted receiver never raises idle
  p_mute_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (mute && !status[B_IDL]) |=> !status[B_IDL]);

  // R8: disabled idle transmitter forces complete
  p_tc_forced_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_tx_en && !tx_busy) |=> status[B_TCF]);

  // R9: data-register write empties transmit register
  p_txe_write_r9: assert property (@(posedge clk) disable iff (rst)
    tdr_write |=> !status[B_TXE]);

  // R12: no enables, no interrupt
  p_irq_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (ie == '0) |=> !irq);
endmodule

bind uart_flag_unit uart_flag_unit_chk i_chk (
  .clk(clk), .rst(rst), .ev_parity_err(ev_parity_err), .ev_frame_rx(ev_frame_rx),
  .tx_busy(tx_busy), .cfg_tx_en(cfg_tx_en), .cfg_ovr_dis(cfg_ovr_dis), .mute(mute),
  .ie(ie), .clr_wr(clr_wr), .clr_data(clr_data), .tdr_write(tdr_write),
  .status(status), .irq(irq)
);

// File: tb/test_uart_flag_unit.sv
module test_uart_flag_unit;
  localparam int SW = 13;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_parity_err = 0, ev_frame_err = 0, ev_noise = 0, ev_frame_rx = 0;
  logic ev_idle = 0, ev_char_match = 0, ev_tx_load = 0, ev_tx_done = 0;
  logic ev_break_done = 0, ev_rx_start = 0, ev_rx_end = 0, tx_busy = 0;
  logic cts_n_in = 1, cfg_tx_en = 1, cfg_cts_flow_en = 0, cfg_ovr_dis = 0, mute = 0;
  logic [7:0]    ie = '0;
  logic          clr_wr = 0;
  logic [SW-1:0] clr_data = '0;
  logic rdr_read = 0, rx_flush = 0, tdr_write = 0, break_req = 0;
  logic [SW-1:0] status;
  logic rx_ready, tx_empty, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_flag_unit #(.SYNC_STAGES(SYNC)) i_uart_flag_unit (
    .clk(clk), .rst(rst), .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
    .ev_noise(ev_noise), .ev_frame_rx(ev_frame_rx), .ev_idle(ev_idle),
    .ev_char_match(ev_char_match), .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done),
    .ev_break_done(ev_break_done), .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end),
    .tx_busy(tx_busy), .cts_n_in(cts_n_in), .cfg_tx_en(cfg_tx_en),
    .cfg_cts_flow_en(cfg_cts_flow_en), .cfg_ovr_dis(cfg_ovr_dis), .mute(mute),
    .ie(ie), .clr_wr(clr_wr), .clr_data(clr_data), .rdr_read(rdr_read),
    .rx_flush(rx_flush), .tdr_write(tdr_write), .break_req(break_req),
    .status(status), .rx_ready(rx_ready), .tx_empty(tx_empty), .irq(irq)
  );

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, string what, logic [SW-1:0] got, logic [SW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic clear_bits(logic [SW-1:0] m);
    clr_wr = 1; clr_data = m; step(); clr_wr = 0; clr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1", "status after reset", status, 13'h0080);
    chk("R1", "irq after reset", {12'b0, irq}, 13'h0);
  endtask

  task automatic t_simple();
    ev_parity_err = 1; ev_frame_err = 1; ev_noise = 1; ev_char_match = 1; step();
    ev_parity_err = 0; ev_frame_err = 0; ev_noise = 0; ev_char_match = 0;
    chk("R2", "error flags set", status & 13'h0807, 13'h0807);
    clear_bits(13'h0000);
    chk("R2", "zero clear keeps", status & 13'h0807, 13'h0807);
    clear_bits(13'h0005);
    chk("R2", "partial clear", status & 13'h0807, 13'h0802);
    clear_bits(13'h0802);
    chk("R2", "rest cleared", status & 13'h0807, 13'h0000);
    // R3: set and clear collide
    ev_parity_err = 1; clr_wr = 1; clr_data = 13'h0001; step();
    ev_parity_err = 0; clr_wr = 0; clr_data = '0;
    chk("R3", "set beats clear", {12'b0, status[0]}, 13'h1);
    clear_bits(13'h0001);
  endtask

  task automatic t_rx();
    ev_frame_rx = 1; step(); ev_frame_rx = 0;
    chk("R6", "rx ready set", {12'b0, rx_ready}, 13'h1);
    chk("R4", "no overrun on first", {12'b0, status[3]}, 13'h0);
    ev_frame_rx = 1; step(); ev_frame_rx = 0;
    chk("R4", "overrun + ready", {11'b0, status[5], status[3]}, 13'h3);
    rdr_read = 1; step(); rdr_read = 0;
    chk("R6", "read clears ready", {12'b0, rx_ready}, 13'h0);
    clear_bits(13'h0008);
    chk("R4", "overrun cleared", {12'b0, status[3]}, 13'h0);
    cfg_ovr_dis = 1;
    ev_frame_rx = 1; step(); ev_frame_rx = 1; step(); ev_frame_rx = 0;
    chk("R5", "overrun held low", {12'b0, status[3]}, 13'h0);
    cfg_ovr_dis = 0;
    rx_flush = 1; step(); rx_flush = 0;
    chk("R6", "flush clears ready", {12'b0, rx_ready}, 13'h0);
  endtask

  task automatic t_idle();
    // armed since the last frame in t_rx
    ev_idle = 1; step(); ev_idle = 0;
    chk("R7", "idle sets when armed", {12'b0, status[4]}, 13'h1);
    clear_bits(13'h0010);
    ev_idle = 1; step(); ev_idle = 0;
    chk("R7", "idle not re-armed", {12'b0, status[4]}, 13'h0);
    ev_frame_rx = 1; step(); ev_frame_rx = 0;
    rdr_read = 1; step(); rdr_read = 0;
    mute = 1; ev_idle = 1; step(); ev_idle = 0;
    chk("R7", "idle ignored in mute", {12'b0, status[4]}, 13'h0);
    mute = 0; ev_idle = 1; step(); ev_idle = 0;
    chk("R7", "idle after rearm", {12'b0, status[4]}, 13'h1);
    clear_bits(13'h0010);
  endtask

  task automatic t_tx();
    ev_tx_done = 1; step(); ev_tx_done = 0;
    chk("R8", "tc sets with txe", {12'b0, status[6]}, 13'h1);
    tdr_write = 1; step(); tdr_write = 0;
    chk("R8", "write clears tc", {12'b0, status[6]}, 13'h0);
    chk("R9", "write clears txe", {12'b0, tx_empty}, 13'h0);
    ev_tx_done = 1; step(); ev_tx_done = 0;
    chk("R8", "no tc without txe", {12'b0, status[6]}, 13'h0);
    ev_tx_load = 1; step(); ev_tx_load = 0;
    chk("R9", "load sets txe", {12'b0, tx_empty}, 13'h1);
    ev_tx_load = 1; tdr_write = 1; step(); ev_tx_load = 0; tdr_write = 0;
    chk("R9", "write wins over load", {12'b0, tx_empty}, 13'h0);
    cfg_tx_en = 0; tx_busy = 1; step();
    chk("R8", "busy blocks force", {12'b0, status[6]}, 13'h0);
    tx_busy = 0; step();
    chk("R8", "disabled forces tc", {12'b0, status[6]}, 13'h1);
    clear_bits(13'h0040);
    chk("R8", "forced tc ignores clear", {12'b0, status[6]}, 13'h1);
    cfg_tx_en = 1;
    clear_bits(13'h0040);
    chk("R8", "clear after enable", {12'b0, status[6]}, 13'h0);
    ev_tx_load = 1; step(); ev_tx_load = 0;
  endtask

  task automatic t_cts();
    cts_n_in = 0; step();
    chk("R10", "level not yet", {12'b0, status[9]}, 13'h0);
    step();
    chk("R10", "level after sync", {12'b0, status[9]}, 13'h1);
    step();
    chk("R10", "no change flag when off", {12'b0, status[8]}, 13'h0);
    cfg_cts_flow_en = 1;
    cts_n_in = 1; step(); step();
    chk("R10", "level back", {12'b0, status[9]}, 13'h0);
    step();
    chk("R10", "change flag set", {12'b0, status[8]}, 13'h1);
    clear_bits(13'h0100);
    chk("R10", "change cleared", {12'b0, status[8]}, 13'h0);
    cfg_cts_flow_en = 0;
  endtask

  task automatic t_busy_break();
    ev_rx_start = 1; break_req = 1; step(); ev_rx_start = 0; break_req = 0;
    chk("R11", "busy and break set", {11'b0, status[12], status[10]}, 13'h3);
    ev_rx_end = 1; ev_break_done = 1; step(); ev_rx_end = 0; ev_break_done = 0;
    chk("R11", "busy and break cleared", {11'b0, status[12], status[10]}, 13'h0);
    clear_bits(13'h1400);
  endtask

  task automatic t_irq();
    ev_noise = 1; step(); ev_noise = 0;
    ie = 8'h08; step(); step();
    chk("R12", "noise not on rx enable", {12'b0, irq}, 13'h0);
    ie = 8'h02; step();
    chk("R12", "noise on error enable", {12'b0, irq}, 13'h1);
    ie = 8'h00; clear_bits(13'h0004); step();
    chk("R12", "irq drops", {12'b0, irq}, 13'h0);
    ev_frame_rx = 1; step(); ev_frame_rx = 1; step(); ev_frame_rx = 0;
    rdr_read = 1; step(); rdr_read = 0;
    ie = 8'h08; step();
    chk("R12", "overrun on rx enable", {12'b0, irq}, 13'h1);
    ie = 8'h00; clear_bits(13'h0008);
    ev_parity_err = 1; ie = 8'h01; step(); ev_parity_err = 0;
    chk("R12", "irq one cycle late", {12'b0, irq}, 13'h0);
    step();
    chk("R12", "parity irq", {12'b0, irq}, 13'h1);
    ie = 8'h00; clear_bits(13'h0001);
  endtask

  initial begin
    repeat (3) step();
    rst = 0; step();
    t_reset();
    t_simple();
    t_rx();
    t_idle();
    t_tx();
    t_cts();
    t_busy_break();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule